// File: doc/BRIEF.md
# ADC Autoscan Channel Sequencer

This block is the digital controller for a 16-input successive-approximation converter. Software programs it through a small register bus. A first control register selects the channel where a scan begins and the channel pair whose results are range-checked. A second control register holds the clock prescaler, the power-up, continuous and start bits, and two gate enables that are stored but have no function here. A write to the second register also restarts the scan.

Once powered and started, the sequencer asks the converter for one conversion per channel. It begins at the start channel and counts upward until channel 15 is done. Each 10-bit result goes into a per-channel result register, and a one-cycle end-of-scan pulse follows the final store. In continuous mode the scan starts over at once. Otherwise the start bit clears itself.

Two window comparators watch a selectable channel and the channel just above it, with wrap from 15 to 0. Each has its own upper and lower limit. A sticky flag is raised when a stored result falls outside its limits. The converter is external. It receives a request strobe and a channel number on ADC-clock ticks, and it answers with a done strobe and the data.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, control register 1 (address 0) reads 0x0F, control register 2 (address 1) reads 0xA0, and `busy`, `eos`, `conv_req` and both window flags are 0.
- R2: `adc_clk_en` pulses once every 2 × (P + 1) system clocks, where P is control register 2 bits 7:5. Requests occur only in the cycle after a pulse. With a converter that answers after L ticks, consecutive requests within a scan are (L + 1) × 2 × (P + 1) cycles apart.
- R3: A scan requests the channels from S (control register 1 bits 7:4) up to 15, in order, one request each. If S = 15, exactly one conversion is made.
- R4: Each result is stored per channel and reads back in the low 10 bits at address 16 + channel, one cycle after the address is presented.
- R5: `eos` is high for exactly one cycle, the cycle after the channel-15 result is stored. If continuous (control register 2 bit 1) is clear, the start bit (bit 0) reads 0 afterwards and `busy` is low.
- R6: If continuous is set, the scan restarts at S without a gap, and the start bit stays 1.
- R7: Any write to control register 2 abandons the current scan. If power-up (bit 2) and start are both set, the next request is for channel S.
- R8: Channel A is control register 1 bits 3:0 and channel B is A + 1 mod 16. Each has an upper and a lower limit (A: addresses 2 and 3, B: 4 and 5). A flag becomes 1 when a stored result is strictly above the upper limit or strictly below the lower limit. A result equal to a limit does not set it. Flags hold until the next write to control register 2 clears them.
- R9: While power-up is 0, no request is made and `busy` stays 0, even with start set.
- R10: All registers written over the bus read back as written, one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address (16–31: results) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, one cycle after address |
| adc_clk_en | output | 1 | ADC clock tick, one system clock wide |
| conv_req | output | 1 | Conversion request strobe |
| conv_ch | output | 4 | Channel being converted |
| conv_done | input | 1 | Converter result strobe |
| conv_data | input | 10 | Converter result |
| busy | output | 1 | Scan in progress |
| eos | output | 1 | End-of-scan pulse |
| win_flag_a | output | 1 | Channel A out of window |
| win_flag_b | output | 1 | Channel B out of window |

## Verification
A control-register write takes effect at the next clock edge, and the scan state reacts one edge after that. A request appears one cycle after an `adc_clk_en` tick. A result, its window flag and `eos` all become visible one cycle after `conv_done`, and read data arrives one cycle after the address. The bench drives inputs on falling edges and samples one falling edge after each of these delays. It logs every request with its cycle stamp from the rising edge, so request spacing and channel order are checked against arithmetic over the prescaler value and the stub latency. It starts counting requests only after the restart edge has passed, so a request issued before a restart is not counted as part of the new scan.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int CH_W   = 4;
  localparam int NCH    = 1 << CH_W;
  localparam int REG_W  = 8;
  localparam int PR_W   = 3;
  localparam int ADR_W  = CH_W + 1;
  localparam int N_WIN  = 2;

  localparam logic [REG_W-1:0] CTL1_RST = 8'h0F;
  localparam logic [REG_W-1:0] CTL2_RST = 8'hA0;

  // control register 2 bit positions
  localparam int BIT_ST   = 0;
  localparam int BIT_CONT = 1;
  localparam int BIT_POW  = 2;
  localparam int PR_LSB   = 5;

  localparam logic [ADR_W-1:0] ADR_CTL1 = 5'd0;
  localparam logic [ADR_W-1:0] ADR_CTL2 = 5'd1;
  localparam logic [ADR_W-1:0] ADR_THR0 = 5'd2;

  localparam logic [CH_W-1:0] CH_LAST = '1;

  typedef enum logic [1:0] {SQ_IDLE, SQ_REQ, SQ_WAIT} seq_state_t;
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div
  import adc_scan_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [PR_W-1:0] pr,
  output logic            tick
);
  localparam int CNT_W = PR_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  // period 2*(pr+1) -> terminal count 2*pr+1
  assign last = {pr, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= last) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
  import adc_scan_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            pow,
  input  logic            st,
  input  logic            cont,
  input  logic            restart,
  input  logic            tick,
  input  logic            conv_done,
  input  logic [CH_W-1:0] start_ch,
  output logic            conv_req,
  output logic [CH_W-1:0] cur_ch,
  output logic            store_we,
  output logic            st_clr,
  output logic            eos,
  output logic            busy
);
  seq_state_t state;

  assign store_we = (state == SQ_WAIT) && conv_done && pow && !restart;
  assign st_clr   = store_we && (cur_ch == CH_LAST) && !cont;
  assign busy     = (state != SQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      cur_ch   <= '0;
      conv_req <= 1'b0;
      eos      <= 1'b0;
    end else begin
      conv_req <= 1'b0;
      eos      <= 1'b0;
      if (restart || !pow) begin
        state  <= (restart && pow && st) ? SQ_REQ : SQ_IDLE;
        cur_ch <= start_ch;
      end else begin
        case (state)
          SQ_IDLE: if (st) begin
            state  <= SQ_REQ;
            cur_ch <= start_ch;
          end
          SQ_REQ: if (tick) begin
            conv_req <= 1'b1;
            state    <= SQ_WAIT;
          end
          SQ_WAIT: if (conv_done) begin
            if (cur_ch == CH_LAST) begin
              eos    <= 1'b1;
              cur_ch <= start_ch;
              state  <= cont ? SQ_REQ : SQ_IDLE;
            end else begin
              cur_ch <= cur_ch + 1'b1;
              state  <= SQ_REQ;
            end
          end
          default: state <= SQ_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_win_cmp.sv
module adc_win_cmp
  import adc_scan_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             store_we,
  input  logic [CH_W-1:0]  store_ch,
  input  logic [CH_W-1:0]  watch_ch,
  input  logic [RES_W-1:0] value,
  input  logic [RES_W-1:0] hi,
  input  logic [RES_W-1:0] lo,
  output logic             out_flag
);
  always_ff @(posedge clk) begin
    if (rst || clr)
      out_flag <= 1'b0;
    else if (store_we && (store_ch == watch_ch) && ((value > hi) || (value < lo)))
      out_flag <= 1'b1;
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              adc_clk_en,
  output logic              conv_req,
  output logic [CH_W-1:0]   conv_ch,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  output logic              busy,
  output logic              eos,
  output logic              win_flag_a,
  output logic              win_flag_b
);
  logic [REG_W-1:0] ctl1_q, ctl2_q;
  logic [RES_W-1:0] thr_hi [N_WIN];
  logic [RES_W-1:0] thr_lo [N_WIN];
  logic             restart_q;
  logic             store_we, st_clr;
  logic [CH_W-1:0]  store_ch;
  logic [N_WIN-1:0] win_flags;

  logic [RES_W-1:0]  res_mem [NCH];
  logic [RES_W-1:0]  mem_q;
  logic [DATA_W-1:0] reg_rd, reg_q;
  logic              sel_mem_q;

  wire ctl2_wr = bus_wr && (bus_addr == ADR_CTL2);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl1_q    <= CTL1_RST;
      ctl2_q    <= CTL2_RST;
      restart_q <= 1'b0;
      for (int i = 0; i < N_WIN; i++) begin
        thr_hi[i] <= '1;
        thr_lo[i] <= '0;
      end
    end else begin
      restart_q <= ctl2_wr;
      if (bus_wr && (bus_addr == ADR_CTL1)) ctl1_q <= bus_wdata[REG_W-1:0];
      if (ctl2_wr) ctl2_q <= bus_wdata[REG_W-1:0];
      else if (st_clr) ctl2_q[BIT_ST] <= 1'b0;
      for (int i = 0; i < N_WIN; i++) begin
        if (bus_wr && (bus_addr == ADR_THR0 + ADR_W'(2*i)))     thr_hi[i] <= bus_wdata[RES_W-1:0];
        if (bus_wr && (bus_addr == ADR_THR0 + ADR_W'(2*i + 1))) thr_lo[i] <= bus_wdata[RES_W-1:0];
      end
    end
  end

  adc_clk_div u_div (
    .clk  (clk),
    .rst  (rst),
    .pr   (ctl2_q[PR_LSB +: PR_W]),
    .tick (adc_clk_en)
  );

  adc_scan_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .pow       (ctl2_q[BIT_POW]),
    .st        (ctl2_q[BIT_ST]),
    .cont      (ctl2_q[BIT_CONT]),
    .restart   (restart_q),
    .tick      (adc_clk_en),
    .conv_done (conv_done),
    .start_ch  (ctl1_q[REG_W-1 -: CH_W]),
    .conv_req  (conv_req),
    .cur_ch    (store_ch),
    .store_we  (store_we),
    .st_clr    (st_clr),
    .eos       (eos),
    .busy      (busy)
  );
  assign conv_ch = store_ch;

  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    adc_win_cmp #(.RES_W(RES_W)) u_cmp (
      .clk      (clk),
      .rst      (rst),
      .clr      (restart_q),
      .store_we (store_we),
      .store_ch (store_ch),
      .watch_ch (ctl1_q[CH_W-1:0] + CH_W'(g)),
      .value    (conv_data),
      .hi       (thr_hi[g]),
      .lo       (thr_lo[g]),
      .out_flag (win_flags[g])
    );
  end
  assign win_flag_a = win_flags[0];
  assign win_flag_b = win_flags[1];

  // result store: plain synchronous RAM, registered read
  always_ff @(posedge clk) begin
    if (store_we) res_mem[store_ch] <= conv_data;
    mem_q <= res_mem[bus_addr[CH_W-1:0]];
  end

  always_comb begin
    reg_rd = '0;
    if (bus_addr == ADR_CTL1) reg_rd[REG_W-1:0] = ctl1_q;
    if (bus_addr == ADR_CTL2) reg_rd[REG_W-1:0] = ctl2_q;
    for (int i = 0; i < N_WIN; i++) begin
      if (bus_addr == ADR_THR0 + ADR_W'(2*i))     reg_rd[RES_W-1:0] = thr_hi[i];
      if (bus_addr == ADR_THR0 + ADR_W'(2*i + 1)) reg_rd[RES_W-1:0] = thr_lo[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q     <= '0;
      sel_mem_q <= 1'b0;
    end else begin
      reg_q     <= reg_rd;
      sel_mem_q <= bus_addr[ADR_W-1];
    end
  end

  assign bus_rdata = sel_mem_q ? {{(DATA_W-RES_W){1'b0}}, mem_q} : reg_q;
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk
  import adc_scan_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            adc_clk_en,
  input logic            conv_req,
  input logic            eos,
  input logic            busy,
  input logic            win_flag_a,
  input logic            win_flag_b,
  input logic            pow,
  input logic            restart,
  input logic            store_we,
  input logic [CH_W-1:0] store_ch
);
  assert_req_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    conv_req |-> $past(adc_clk_en));

  assert_req_single_R3: assert property (@(posedge clk) disable iff (rst)
    conv_req |=> !conv_req);

  assert_eos_single_R5: assert property (@(posedge clk) disable iff (rst)
    eos |=> !eos);

  assert_eos_after_last_R5: assert property (@(posedge clk) disable iff (rst)
    eos |-> ($past(store_we) && ($past(store_ch) == CH_LAST)));

  assert_unpowered_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (!pow && $past(!pow)) |-> (!conv_req && !busy));

  assert_flag_a_hold_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(win_flag_a) && !$past(restart)) |-> win_flag_a);

  assert_flag_b_hold_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(win_flag_b) && !$past(restart)) |-> win_flag_b);
endmodule

bind adc_scan_seq adc_scan_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .adc_clk_en (adc_clk_en),
  .conv_req   (conv_req),
  .eos        (eos),
  .busy       (busy),
  .win_flag_a (win_flag_a),
  .win_flag_b (win_flag_b),
  .pow        (ctl2_q[BIT_POW]),
  .restart    (restart_q),
  .store_we   (store_we),
  .store_ch   (store_ch)
);

// File: tb/adc_scan_seq_test.sv
module adc_scan_seq_test;
  import adc_scan_pkg::*;
  localparam int LAT    = 3;
  localparam int RES_W  = 10;
  localparam int DATA_W = 16;
  localparam int LOGN   = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic              bus_wr = 1'b0;
  logic [ADR_W-1:0]  bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              adc_clk_en, conv_req, conv_done, busy, eos, win_flag_a, win_flag_b;
  logic [CH_W-1:0]   conv_ch;
  logic [RES_W-1:0]  conv_data;

  adc_scan_seq uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .adc_clk_en(adc_clk_en), .conv_req(conv_req), .conv_ch(conv_ch),
    .conv_done(conv_done), .conv_data(conv_data), .busy(busy), .eos(eos),
    .win_flag_a(win_flag_a), .win_flag_b(win_flag_b)
  );

  int seed = 0;
  function automatic int model(int ch, int s);
    return 100 + ch * 37 + s * 5;
  endfunction

  // converter stub: a new request cancels any pending one
  logic       pend;
  int         cnt_l;
  int         ch_l;
  always @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0; conv_done <= 1'b0; conv_data <= '0; cnt_l <= 0; ch_l <= 0;
    end else begin
      conv_done <= 1'b0;
      if (conv_req) begin
        pend <= 1'b1; cnt_l <= LAT; ch_l <= int'(conv_ch);
      end else if (pend && adc_clk_en) begin
        if (cnt_l == 1) begin
          pend <= 1'b0; conv_done <= 1'b1; conv_data <= RES_W'(model(ch_l, seed));
        end else cnt_l <= cnt_l - 1;
      end
    end
  end

  // monitor
  int cyc = 0, req_n = 0, eos_cnt = 0, tick_last = 0, tick_prev = 0;
  int log_ch [LOGN];
  int log_t  [LOGN];
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst) begin
      if (conv_req) begin
        if (req_n < LOGN) begin
          log_ch[req_n] <= int'(conv_ch);
          log_t[req_n]  <= cyc;
        end
        req_n <= req_n + 1;
      end
      if (eos) eos_cnt <= eos_cnt + 1;
      if (adc_clk_en) begin
        tick_prev <= tick_last;
        tick_last <= cyc;
      end
    end
  end

  int n_chk = 0, n_bad = 0;
  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = ADR_W'(a); bus_wdata = DATA_W'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk);
    bus_addr = ADR_W'(a);
    @(negedge clk);
    v = int'(bus_rdata);
  endtask

  task automatic wait_eos(int target, string tag);
    int k = 0;
    while (eos_cnt < target && k < 5000) begin
      @(negedge clk);
      k++;
    end
    if (eos_cnt < target) check({tag, " eos timeout"}, eos_cnt, target);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog all R: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    int v, base, e0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset values
    check("R1 busy", int'(busy), 0);
    check("R1 eos", int'(eos), 0);
    check("R1 conv_req", int'(conv_req), 0);
    check("R1 flags", int'({win_flag_a, win_flag_b}), 0);
    rd(0, v); check("R1 ctl1", v, 'h0F);
    rd(1, v); check("R1 ctl2", v, 'hA0);

    // R10 threshold readback
    for (int a = 2; a < 6; a++) begin
      wr(a, 'h155 + a * 64);
      rd(a, v);
      check("R10 thr readback", v, ('h155 + a * 64) & 'h3FF);
    end

    // R2 prescaler sweep, powered but not started
    for (int p = 0; p < 8; p++) begin
      wr(1, (p << 5) | 'h04);
      repeat (40) @(negedge clk);
      check($sformatf("R2 tick period pr=%0d", p), tick_last - tick_prev, 2 * (p + 1));
      check("R9/R2 no req while not started", int'(busy), 0);
    end

    // R3/R4/R5/R8 scan sweep over every start channel
    for (int s = 0; s < 16; s++) begin
      int pr, cc, cha, chb, ratio, va, vb, ma, mb, na;
      seed = s;
      pr = s % 8; ratio = 2 * (pr + 1);
      cc = (s * 5 + 7) % 16; cha = cc; chb = (cc + 1) % 16;
      va = model(cha, seed); vb = model(chb, seed);
      ma = s % 3; mb = (s + 1) % 3;
      wr(2, ma == 0 ? va - 1 : (ma == 1 ? va : 1023));
      wr(3, ma == 0 ? 0 : (ma == 1 ? va : va + 1));
      wr(4, mb == 0 ? vb - 1 : (mb == 1 ? vb : 1023));
      wr(5, mb == 0 ? 0 : (mb == 1 ? vb : vb + 1));
      wr(0, (s << 4) | cc);
      e0 = eos_cnt;
      wr(1, (pr << 5) | 'h05);
      @(negedge clk);
      base = req_n;
      wait_eos(e0 + 1, "R5");
      repeat (3 * ratio * (LAT + 1)) @(negedge clk);
      na = req_n - base;
      check($sformatf("R3 request count start=%0d", s), na, 16 - s);
      for (int k = 0; k < na && k < 16; k++) begin
        check("R3 channel order", log_ch[base + k], s + k);
        if (k > 0) check("R2 request spacing", log_t[base + k] - log_t[base + k - 1], (LAT + 1) * ratio);
      end
      check("R5 eos count", eos_cnt - e0, 1);
      check("R5 busy after scan", int'(busy), 0);
      rd(1, v); check("R5 start bit cleared", v & 1, 0);
      check("R8 flag A", int'(win_flag_a), (cha >= s && ma != 1) ? 1 : 0);
      check("R8 flag B", int'(win_flag_b), (chb >= s && mb != 1) ? 1 : 0);
      for (int c = s; c < 16; c++) begin
        rd(16 + c, v);
        check($sformatf("R4 result ch%0d", c), v, model(c, seed));
      end
    end

    // R6 continuous mode
    seed = 20;
    wr(0, 'hC0);
    e0 = eos_cnt;
    wr(1, 'h07);
    @(negedge clk);
    base = req_n;
    wait_eos(e0 + 2, "R6");
    for (int k = 0; k < 8; k++) begin
      check("R6 continuous order", log_ch[base + k], 12 + k % 4);
      if (k > 0) check("R6 spacing across wrap", log_t[base + k] - log_t[base + k - 1], (LAT + 1) * 2);
    end
    check("R6 busy stays", int'(busy), 1);
    rd(1, v); check("R6 start bit kept", v & 1, 1);
    wr(1, 'h04);
    repeat (4) @(negedge clk);
    check("R7 stop by write", int'(busy), 0);

    // R7 restart mid-scan, R8 flag clear
    seed = 40;
    wr(2, 0); wr(3, 0);
    wr(0, 'h23);
    wr(1, 'h25);
    @(negedge clk);
    base = req_n;
    while (req_n - base < 3) @(negedge clk);
    check("R8 flag A set above upper", int'(win_flag_a), 1);
    wr(0, 'h93);
    e0 = eos_cnt;
    wr(1, 'h25);
    @(negedge clk);
    check("R8 flag cleared by restart", int'(win_flag_a), 0);
    base = req_n;
    wait_eos(e0 + 1, "R7");
    repeat (40) @(negedge clk);
    check("R7 request count after restart", req_n - base, 7);
    for (int k = 0; k < 7; k++) check("R7 order after restart", log_ch[base + k], 9 + k);
    for (int c = 9; c < 16; c++) begin
      rd(16 + c, v);
      check("R7/R4 result after restart", v, model(c, seed));
    end
    check("R8 flag A stays clear", int'(win_flag_a), 0);

    // R9 power-up clear ignores start
    e0 = eos_cnt;
    wr(1, 'h01);
    @(negedge clk);
    base = req_n;
    repeat (300) @(negedge clk);
    check("R9 no requests", req_n - base, 0);
    check("R9 not busy", int'(busy), 0);
    check("R9 no eos", eos_cnt - e0, 0);
    rd(1, v); check("R10 ctl2 readback", v, 'h01);

    summary();
    $finish;
  end
endmodule